// File: doc/BRIEF.md
# Syndrome-Count Self-Test Checker

This block tests an external single-output combinational function of `N_IN` inputs by applying every possible input word to it and counting how many of those words make the output high. The count of ones over the full input space (the number of minterms the function realises) is the only stored expectation: the tester compares it for equality against a reference value at the end of the sweep. It does not compare the response to each pattern separately.

A run begins with a one-cycle `start` request while the block is idle. The block then steps an ascending pattern word from zero to all ones. It holds each word for `SETTLE+1` clock cycles so that the external logic has time to settle, and it captures the response bit at the end of each hold. When the sweep ends, `busy` drops and `done` rises together with a registered `fail` flag. Both stay valid until the next run is started. A pass only proves the function is fault-free when the function was built so that no single fault keeps its ones count unchanged. A faulty function that realises the same number of minterms passes.

Top module: `syndrome_selftest`

## Requirements
- R1: After reset `busy`, `done` and `fail` are low and `pattern` is zero.
- R2: A `start` high at a clock edge while `busy` is low sets `busy`, clears `done` and `fail`, and sets `pattern` to zero at that edge.
- R3: During a run `pattern` takes the values 0, 1, ..., 2^N_IN-1 in ascending binary order, and each value is held for exactly `SETTLE+1` cycles.
- R4: The response to a pattern is captured at the last edge of that pattern's hold interval, `SETTLE+1` edges after the pattern was driven. A response that arrives with a delay of up to `SETTLE` cycles is therefore counted correctly.
- R5: `done` rises and `busy` falls at the edge that is 2^N_IN*(SETTLE+1) edges after the start edge. At that edge `fail` is set to 1 when the number of captured ones differs from `ref_count`, and to 0 when they are equal.
- R6: `done` and `fail` keep their values until the next accepted `start`, and that start clears `done`.
- R7: A `start` received while `busy` is high is ignored. The pattern sequence and the finish time of the current run are unchanged.
- R8: The ones count is `N_IN+1` bits wide, so a function that is high for all 2^N_IN patterns passes against a reference of 2^N_IN.
- R9: A faulty function that realises the same number of minterms as the reference passes (`fail` = 0), because only the count is compared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Run request, acted on only while idle |
| ref_count | input | N_IN+1 | Expected number of ones over the full sweep |
| resp | input | 1 | Output bit of the function under test |
| pattern | output | N_IN | Input word driven to the function under test |
| busy | output | 1 | High while a sweep is running |
| done | output | 1 | High from the end of a sweep until the next start |
| fail | output | 1 | Registered verdict, 1 when the count differs from the reference |

## Verification
The bench models the function under test with a response that lags the pattern by `SETTLE` cycles. A design that sampled even one cycle early would count responses to the wrong patterns and report a wrong verdict for an asymmetric function. An all-ones function needs a count of 2^N_IN. A count register one bit too narrow would wrap to zero and flag a fault on a good function. Start pulses injected in the middle of a sweep would restart the pattern sequence and delay the finish if the busy guard were missing. A faulty function that keeps the same minterm count must still pass, which exposes a design that compares anything beyond the count. The bench also checks that the verdict stays unchanged while idle, which would fail if `done` or `fail` were cleared without a start.

// File: rtl/syndrome_selftest.sv
module syndrome_selftest #(
  parameter int N_IN   = 4,
  parameter int SETTLE = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [N_IN:0]   ref_count,
  input  logic            resp,
  output logic [N_IN-1:0] pattern,
  output logic            busy,
  output logic            done,
  output logic            fail
);
  localparam int CW = N_IN + 1;
  localparam int WW = (SETTLE > 0) ? $clog2(SETTLE + 1) : 1;
  localparam logic [WW-1:0]   WLAST = WW'(SETTLE);
  localparam logic [N_IN-1:0] PLAST = '1;

  logic [CW-1:0] ones_q;
  logic [WW-1:0] hold_q;

  wire           take     = busy && (hold_q == WLAST);
  wire           last     = take && (pattern == PLAST);
  wire [CW-1:0]  ones_nxt = ones_q + CW'(resp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pattern <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      fail    <= 1'b0;
      ones_q  <= '0;
      hold_q  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy    <= 1'b1;
        done    <= 1'b0;
        fail    <= 1'b0;
        pattern <= '0;
        ones_q  <= '0;
        hold_q  <= '0;
      end
    end else if (take) begin
      ones_q <= ones_nxt;
      hold_q <= '0;
      if (last) begin
        busy <= 1'b0;
        done <= 1'b1;
        fail <= (ones_nxt != ref_count);
      end else begin
        pattern <= pattern + 1'b1;
      end
    end else begin
      hold_q <= hold_q + 1'b1;
    end
  end

  // R5: running and finished are never reported together
  a_r5_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R3: while running, the pattern only ever advances by one
  a_r3_pattern_step: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && (pattern != $past(pattern)) |-> pattern == $past(pattern) + 1'b1);

  // R5: a sweep ends only after the last pattern was on the output
  a_r5_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy) && ($past(pattern) == PLAST));

  // R6: verdict holds while no start arrives
  a_r6_verdict_hold: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(fail));

  // R7: a start during a run does not send the pattern back to zero
  a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && (pattern != '0) |=> pattern != '0);

  // R8: the count never passes the number of patterns
  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ones_q <= (CW'(1) << N_IN));
endmodule

// File: tb/syndrome_selftest_tb.sv
module syndrome_selftest_tb_top;
  localparam int NB    = 4;
  localparam int ST    = 2;
  localparam int SWEEP = (1 << NB) * (ST + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [NB:0]   ref_count = '0;
  logic [NB-1:0] pattern;
  logic          busy, done, fail;
  logic          resp;
  int            sel = 0;
  int            checks = 0;
  int            errors = 0;
  logic [NB-1:0] lag1, lag2;

  always #4 clk = ~clk;

  syndrome_selftest #(.N_IN(NB), .SETTLE(ST)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .ref_count(ref_count),
    .resp(resp), .pattern(pattern), .busy(busy), .done(done), .fail(fail)
  );

  // function under test sees the pattern ST (=2) cycles late
  always_ff @(posedge clk) begin
    lag1 <= pattern;
    lag2 <= lag1;
  end

  function automatic logic fut(int s, logic [NB-1:0] p);
    case (s)
      0: fut = 1'b0;
      1: fut = 1'b1;
      2: fut = (p[0] & p[1]) | p[2];
      3: fut = (p[0] & p[3]) | p[2];
      default: fut = p[0] & p[1];
    endcase
  endfunction

  assign resp = fut(sel, lag2);

  function automatic int ones_of(int s);
    int c = 0;
    for (int p = 0; p < (1 << NB); p++) c += int'(fut(s, NB'(p)));
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !fail && pattern == '0, "R1 reset state", {busy, done, fail}, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_run(input int s, input int rf, input int inject, input string tag);
    int n = 0;
    int bad = 0;
    bit exp_fail;
    sel = s;
    ref_count = (NB+1)'(rf);
    exp_fail = (ones_of(s) != rf);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !done && !fail && pattern == '0, {"R2 start accepted ", tag}, int'(busy), 1);
    while (!done && n < 4 * SWEEP) begin
      if (int'(pattern) != n / (ST + 1)) bad++;
      start = (n == inject) || (n == inject + 7);
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    chk(bad == 0, {"R3 pattern order ", tag}, bad, 0);
    chk(n == SWEEP, {"R5 done timing ", tag}, n, SWEEP);
    chk(!busy, {"R5 busy dropped ", tag}, int'(busy), 0);
    chk(fail == exp_fail, {"R5 verdict ", tag}, int'(fail), int'(exp_fail));
  endtask

  task automatic t_hold();
    logic f0;
    f0 = fail;
    repeat (6) @(negedge clk);
    chk(done && fail == f0, "R6 verdict held while idle", int'(fail), int'(f0));
    sel = 0;
    ref_count = '0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!done && !fail && busy, "R6 new start clears done", int'(done), 0);
    while (!done) @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_run(0, 0, -100, "zero fn matches");
    t_run(0, 1, -100, "zero fn mismatch");
    t_run(1, 1 << NB, -100, "R8 all ones count");
    t_run(2, ones_of(2), -100, "R4 lagged response");
    t_run(4, ones_of(2), -100, "fault detected");
    t_hold();
    t_run(3, ones_of(2), -100, "R9 same count alias passes");
    t_run(2, ones_of(2), 20, "R7 start while busy");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule